// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Controller

This controller applies collision-based flow control on a half-duplex Ethernet link when the local receive buffer is filling. When the buffer fill level reaches a programmable high mark, the controller arms a duration timer that counts bit-time ticks. While it is armed it tells the transmit logic to jam each newly arriving frame whose destination class is enabled. The jam causes a collision, so the sender backs off. The jam request is held until receive carrier drops, so that other stations on the segment defer as well.

Jamming never starts in the middle of a frame. A frame start that arrives while the local transmitter is busy is let through. The controller then waits for the next frame start. When the configured duration has elapsed, exactly one received frame is accepted without jamming. When that frame's carrier drops, the buffer level is checked again. If the level is still at or above the high mark, the timer re-arms from zero. Otherwise the controller returns to idle. The controller does nothing unless the link is in half-duplex mode and flow control is enabled.

Top module: `bpj_ctrl`

## Requirements
- R1: After reset, and within one cycle of `half_duplex` or `fc_enable` being low, `jam_req`, `bp_active` and `pass_open` are all 0. While disabled, a high buffer level and frame starts produce no jam.
- R2: While enabled and idle, a `fifo_level` greater than or equal to `hi_thresh` (equality included) sets `bp_active` one cycle later.
- R3: While armed, `jam_req` rises one cycle after an `rx_sof` pulse with `tx_busy` low and an enabled class. Carrier already high without a new `rx_sof` never starts a jam.
- R4: Class filter. `rx_class[0]` means own unicast, `rx_class[1]` means multicast and `rx_class[2]` means broadcast. `class_en[2:0]` enable the matching classes and `class_en[3]` enables every frame. A frame jams only if `class_en[3]` is set or some set `rx_class` bit has its enable set.
- R5: `jam_req` stays high while `rx_crs` is high. It falls one cycle after `rx_crs` is sampled low.
- R6: The duration timer counts cycles with `bit_tick` high while armed or jamming, starting from zero. When the count has reached `dur_cfg` and no jam is in progress, `pass_open` rises on the next cycle and `bp_active` falls.
- R7: While `pass_open` is high, the next `rx_sof` is accepted without a jam, whatever its class, and `pass_open` stays high until that frame's carrier drops.
- R8: One cycle after the accepted frame's carrier drops, `bp_active` is set again if `fifo_level >= hi_thresh`. Otherwise all three outputs are 0.
- R9: An `rx_sof` sampled while `tx_busy` is high does not jam that frame. The next frame start with `tx_busy` low does jam.
- R10: With `dur_cfg` equal to 0, `pass_open` rises two cycles after the high mark is reached, with no frame jammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_duplex | input | 1 | Link is in half-duplex mode |
| fc_enable | input | 1 | Flow control enabled |
| fifo_level | input | LVL_W | Receive buffer fill level |
| hi_thresh | input | LVL_W | High mark that arms backpressure |
| dur_cfg | input | DUR_W | Backpressure duration in bit-time ticks |
| bit_tick | input | 1 | One-cycle tick per timer unit |
| tx_busy | input | 1 | Local transmitter is sending a frame |
| rx_sof | input | 1 | Pulse at the start of a received frame |
| rx_crs | input | 1 | Receive carrier present |
| rx_class | input | 3 | Destination class of the starting frame (own, multicast, broadcast) |
| class_en | input | 4 | Class enables; bit 3 enables any frame |
| jam_req | output | 1 | Request to transmit the jam pattern |
| bp_active | output | 1 | Backpressure armed or jamming |
| pass_open | output | 1 | Duration elapsed; one frame is being accepted |

## Verification
Every output comes straight from a state register, so each response is due exactly one rising edge after the input that causes it. Examples are the high mark for `bp_active`, `rx_sof` for `jam_req`, and carrier drop for the release of `jam_req` or for the re-check of the buffer level. The one exception is `dur_cfg` of zero, where the response takes two edges. The duration path adds one edge after the tick that brings the count to `dur_cfg`. Inputs are driven just after a falling edge. Each check samples on the falling edge that follows the counted number of rising edges, so every expected value lines up with the cycle in which it is due.

// File: rtl/bpj_pkg.sv
`timescale 1ns/1ps
package bpj_pkg;
   localparam int NUM_CLS   = 3;
   localparam int CLS_OWN   = 0;
   localparam int CLS_MCAST = 1;
   localparam int CLS_BCAST = 2;
   localparam int EN_ANY    = NUM_CLS;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ARMED   = 3'd1,
      ST_JAM     = 3'd2,
      ST_PASS    = 3'd3,
      ST_PASS_RX = 3'd4
   } bp_state_t;
endpackage

// File: rtl/bpj_class_match.sv
`timescale 1ns/1ps
module bpj_class_match #(
   parameter int NUM = 3
) (
   input  logic [NUM-1:0] rx_class,
   input  logic [NUM:0]   class_en,
   output logic           match
);
   logic [NUM-1:0] hit;

   generate
      if (NUM < 1) begin : g_bad_num
         $error("bpj_class_match: NUM must be at least 1");
      end
      for (genvar g = 0; g < NUM; g++) begin : g_cls
         assign hit[g] = rx_class[g] & class_en[g];
      end
   endgenerate

   // the top enable bit accepts any frame regardless of its class bits
   assign match = class_en[NUM] | (|hit);
endmodule

// File: rtl/bpj_dur_timer.sv
`timescale 1ns/1ps
module bpj_dur_timer #(
   parameter int DUR_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [DUR_W-1:0] dur_cfg,
   output logic             elapsed
);
   localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

   logic [DUR_W-1:0] cnt;
   logic [DUR_W-1:0] cnt_nxt;

   generate
      if (DUR_W < 1 || DUR_W > 32) begin : g_bad_w
         $error("bpj_dur_timer: DUR_W out of range 1..32");
      end
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

         // R6: a saturating count never moves backwards while running
         a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            (run && $past(run)) |-> (cnt >= $past(cnt)));
      end else begin : g_wrap
         assign cnt_nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (tick)     cnt <= cnt_nxt;
   end

   assign elapsed = (cnt >= dur_cfg);

   // R6: only ticks advance the count
   a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(tick)) |-> (cnt == $past(cnt)));

   // R6: count restarts at zero whenever the timer is parked
   a_r6_parked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run) |-> (cnt == '0));
endmodule

// File: rtl/bpj_fsm.sv
`timescale 1ns/1ps
module bpj_fsm
   import bpj_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable,
   input  logic      over_hi,
   input  logic      elapsed,
   input  logic      rx_sof,
   input  logic      rx_crs,
   input  logic      tx_busy,
   input  logic      cls_match,
   output bp_state_t state,
   output logic      timer_run
);
   bp_state_t state_nxt;

   always_comb begin
      state_nxt = state;
      if (!enable) begin
         state_nxt = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:    if (over_hi) state_nxt = ST_ARMED;
            ST_ARMED: begin
               if (elapsed)                             state_nxt = ST_PASS;
               else if (rx_sof && !tx_busy && cls_match) state_nxt = ST_JAM;
            end
            ST_JAM: begin
               if (!rx_crs) state_nxt = elapsed ? ST_PASS : ST_ARMED;
            end
            ST_PASS:    if (rx_sof) state_nxt = ST_PASS_RX;
            ST_PASS_RX: begin
               if (!rx_crs) state_nxt = over_hi ? ST_ARMED : ST_IDLE;
            end
            default:    state_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nxt;
   end

   assign timer_run = (state == ST_ARMED) || (state == ST_JAM);

   // R1: disabling parks the controller
   a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (state == ST_IDLE));

   // R3: a jam only begins on a frame start seen with the transmitter quiet
   a_r3_start_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_JAM) ##1 (state == ST_JAM) |-> $past(rx_sof && !tx_busy));

   // R5: jam is held for the whole carrier
   a_r5_hold_jam: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_JAM && rx_crs && enable) |=> (state == ST_JAM));

   // R5: jam ends once carrier is gone
   a_r5_release_jam: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_JAM && !rx_crs) |=> (state != ST_JAM));

   // R7: the first frame after the duration is accepted
   a_r7_accept_one: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PASS && rx_sof && enable) |=> (state == ST_PASS_RX));

   // R8: leaving the accepted frame never jumps straight to jamming
   a_r8_reeval: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PASS_RX && !rx_crs) |=> (state == ST_ARMED || state == ST_IDLE));
endmodule

// File: rtl/bpj_ctrl.sv
`timescale 1ns/1ps
module bpj_ctrl
   import bpj_pkg::*;
#(
   parameter int LVL_W    = 12,
   parameter int DUR_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               half_duplex,
   input  logic               fc_enable,
   input  logic [LVL_W-1:0]   fifo_level,
   input  logic [LVL_W-1:0]   hi_thresh,
   input  logic [DUR_W-1:0]   dur_cfg,
   input  logic               bit_tick,
   input  logic               tx_busy,
   input  logic               rx_sof,
   input  logic               rx_crs,
   input  logic [NUM_CLS-1:0] rx_class,
   input  logic [NUM_CLS:0]   class_en,
   output logic               jam_req,
   output logic               bp_active,
   output logic               pass_open
);
   generate
      if (LVL_W < 1 || LVL_W > 32) begin : g_bad_lvl
         $error("bpj_ctrl: LVL_W out of range 1..32");
      end
   endgenerate

   logic      enable;
   logic      over_hi;
   logic      cls_match;
   logic      elapsed;
   logic      timer_run;
   bp_state_t state;

   assign enable  = half_duplex & fc_enable;
   assign over_hi = (fifo_level >= hi_thresh);

   bpj_class_match #(.NUM(NUM_CLS)) u_match (
      .rx_class (rx_class),
      .class_en (class_en),
      .match    (cls_match)
   );

   bpj_dur_timer #(.DUR_W(DUR_W), .SATURATE(SATURATE)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (timer_run),
      .tick    (bit_tick),
      .dur_cfg (dur_cfg),
      .elapsed (elapsed)
   );

   bpj_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .over_hi   (over_hi),
      .elapsed   (elapsed),
      .rx_sof    (rx_sof),
      .rx_crs    (rx_crs),
      .tx_busy   (tx_busy),
      .cls_match (cls_match),
      .state     (state),
      .timer_run (timer_run)
   );

   assign jam_req   = (state == ST_JAM);
   assign bp_active = timer_run;
   assign pass_open = (state == ST_PASS) || (state == ST_PASS_RX);

   // R4: every jam is preceded by a class match on its frame start
   a_r4_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_req) |-> $past(cls_match));

   // R7: no jam while a frame is being let through
   a_r7_no_jam_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
      pass_open |-> !jam_req);

   // R2: arming follows an over-threshold level seen while idle
   a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_active && !pass_open && enable && over_hi) |=> bp_active);
endmodule

// File: tb/test_bpj_ctrl.sv
`timescale 1ns/1ps
module test_bpj_ctrl;
   localparam int LVL_W = 12;
   localparam int DUR_W = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             half_duplex, fc_enable;
   logic [LVL_W-1:0] fifo_level, hi_thresh;
   logic [DUR_W-1:0] dur_cfg;
   logic             bit_tick, tx_busy, rx_sof, rx_crs;
   logic [2:0]       rx_class;
   logic [3:0]       class_en;
   logic             jam_req, bp_active, pass_open;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   bpj_ctrl #(.LVL_W(LVL_W), .DUR_W(DUR_W)) i_bpj_ctrl (
      .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .fc_enable(fc_enable),
      .fifo_level(fifo_level), .hi_thresh(hi_thresh), .dur_cfg(dur_cfg),
      .bit_tick(bit_tick), .tx_busy(tx_busy), .rx_sof(rx_sof), .rx_crs(rx_crs),
      .rx_class(rx_class), .class_en(class_en),
      .jam_req(jam_req), .bp_active(bp_active), .pass_open(pass_open)
   );

   task automatic check(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      bit_tick = 1'b1;
      step(n);
      bit_tick = 1'b0;
   endtask

   task automatic frame_start(input logic [2:0] cls);
      rx_class = cls;
      rx_sof   = 1'b1;
      rx_crs   = 1'b1;
      step(1);
      rx_sof   = 1'b0;
   endtask

   task automatic frame_end();
      rx_crs = 1'b0;
      step(1);
   endtask

   task automatic go_idle();
      fc_enable  = 1'b0;
      fifo_level = '0;
      step(1);
      fc_enable  = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      half_duplex = 1'b1; fc_enable = 1'b1;
      fifo_level = '0; hi_thresh = 12'd100; dur_cfg = 16'd8;
      bit_tick = 1'b0; tx_busy = 1'b0; rx_sof = 1'b0; rx_crs = 1'b0;
      rx_class = 3'b000; class_en = 4'b0001;
      step(3);
      check(jam_req,   1'b0, "R1 reset jam_req");
      check(bp_active, 1'b0, "R1 reset bp_active");
      check(pass_open, 1'b0, "R1 reset pass_open");
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic t_arm_jam_pass();
      fifo_level = 12'd99;
      step(1);
      check(bp_active, 1'b0, "R2 below threshold stays idle");
      fifo_level = 12'd100;
      step(1);
      check(bp_active, 1'b1, "R2 equal level arms");
      check(jam_req,   1'b0, "R3 no jam before frame start");
      frame_start(3'b001);
      check(jam_req, 1'b1, "R3 jam on own frame start");
      step(5);
      check(jam_req, 1'b1, "R5 jam held with carrier");
      frame_end();
      check(jam_req,   1'b0, "R5 jam released after carrier drop");
      check(bp_active, 1'b1, "R6 still armed after jammed frame");
      ticks(7);
      step(1);
      check(pass_open, 1'b0, "R6 not elapsed at dur-1 ticks");
      ticks(1);
      step(1);
      check(pass_open, 1'b1, "R6 pass opens after dur ticks");
      check(bp_active, 1'b0, "R6 armed status clears");
      frame_start(3'b001);
      check(jam_req,   1'b0, "R7 passed frame not jammed");
      check(pass_open, 1'b1, "R7 pass held during frame");
      step(3);
      check(jam_req, 1'b0, "R7 no jam mid passed frame");
      frame_end();
      check(bp_active, 1'b1, "R8 level still high re-arms");
      check(pass_open, 1'b0, "R8 pass closes on re-arm");
      fifo_level = 12'd10;
      ticks(8);
      step(1);
      check(pass_open, 1'b1, "R6 second duration elapses");
      frame_start(3'b100);
      frame_end();
      check(bp_active, 1'b0, "R8 low level returns idle");
      check(pass_open, 1'b0, "R8 idle pass_open");
      frame_start(3'b001);
      check(jam_req, 1'b0, "R8 idle frame not jammed");
      frame_end();
   endtask

   task automatic t_class_filter();
      go_idle();
      fifo_level = 12'd200;
      step(1);
      class_en = 4'b0100;
      frame_start(3'b010);
      check(jam_req, 1'b0, "R4 multicast not enabled");
      frame_end();
      frame_start(3'b100);
      check(jam_req, 1'b1, "R4 broadcast enabled jams");
      frame_end();
      class_en = 4'b1000;
      frame_start(3'b000);
      check(jam_req, 1'b1, "R4 any-frame enable jams");
      frame_end();
      class_en = 4'b0000;
      frame_start(3'b111);
      check(jam_req, 1'b0, "R4 no enables no jam");
      frame_end();
      class_en = 4'b0001;
   endtask

   task automatic t_tx_busy();
      go_idle();
      fifo_level = 12'd150;
      step(1);
      tx_busy = 1'b1;
      frame_start(3'b001);
      check(jam_req, 1'b0, "R9 frame start during transmit not jammed");
      step(2);
      tx_busy = 1'b0;
      step(1);
      check(jam_req, 1'b0, "R9 no jam after transmit ends mid frame");
      frame_end();
      frame_start(3'b001);
      check(jam_req, 1'b1, "R9 next frame start jams");
      frame_end();
      go_idle();
      rx_crs = 1'b1;
      fifo_level = 12'd150;
      step(1);
      check(bp_active, 1'b1, "R3 armed while carrier already up");
      step(3);
      check(jam_req, 1'b0, "R3 no jam without new frame start");
      rx_crs = 1'b0;
      step(1);
   endtask

   task automatic t_disable();
      go_idle();
      half_duplex = 1'b0;
      fifo_level  = 12'd300;
      step(2);
      check(bp_active, 1'b0, "R1 full duplex stays idle");
      frame_start(3'b001);
      check(jam_req, 1'b0, "R1 full duplex no jam");
      frame_end();
      half_duplex = 1'b1;
      step(1);
      check(bp_active, 1'b1, "R2 arms once half duplex");
      frame_start(3'b001);
      check(jam_req, 1'b1, "R3 jam before disable");
      fc_enable = 1'b0;
      step(1);
      check(jam_req, 1'b0, "R1 disable drops jam");
      frame_end();
      fc_enable = 1'b1;
   endtask

   task automatic t_dur_zero();
      go_idle();
      dur_cfg = 16'd0;
      fifo_level = 12'd120;
      step(1);
      check(bp_active, 1'b1, "R10 armed first cycle");
      check(pass_open, 1'b0, "R10 not yet passing");
      step(1);
      check(pass_open, 1'b1, "R10 pass opens second cycle");
      frame_start(3'b001);
      check(jam_req, 1'b0, "R10 no frame jammed");
      frame_end();
      dur_cfg = 16'd8;
   endtask

   initial begin
      t_reset();
      t_arm_jam_pass();
      t_class_filter();
      t_tx_busy();
      t_disable();
      t_dur_zero();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule